// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the time of day and the calendar date as packed BCD register fields: seconds, minutes, hours, day of month, weekday, month and a two-digit year covering 2000 to 2099. An external prescaler supplies a single-cycle pulse once per second. Each accepted pulse advances the seconds field. Any rollover carries into the next field. Month lengths and leap years are handled, so the day field wraps at the right place.

Software reaches the registers through a plain parallel port. A write strobe with an address and a data byte updates a register on the clock edge. The read data always reflects the register selected by the address bus, with no wait. There is no back-pressure: every write is accepted in the cycle it is presented, and reads never stall.

A control register carries a stop bit, which freezes counting while a new time is loaded. It also carries a few mode bits that are only stored. A write whose bits 6, 4 and 3 are all set acts as a software-reset command. A sticky flag in the seconds register records that the oscillator stopped, which tells software that the stored time cannot be trusted.

Top module: `rtc_calendar_core`

## Requirements
- R1: After `rst_n` is released, the registers read as follows: control 0x00, seconds 0x80 (flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 and year 0x00.
- R2: The register map is control at 0x0, then seconds, minutes, hours, day, weekday, month and year at 0x2 through 0x8. The writable bits are: control bits 7, 5, 2, 1; seconds bits 6:0; minutes 6:0; hours and day 5:0; weekday 2:0; month 4:0; year 7:0. Any other bit reads 0. Addresses 0x1 and 0x9 to 0xF read 0, and writes to them change nothing.
- R3: A `tick_1hz` pulse with the stop bit (control bit 5) clear advances seconds by one BCD count. Cycles without a pulse leave the time unchanged.
- R4: Seconds 59 and minutes 59 wrap to 00 and carry into the next field. Hours 23 wraps to 00 and carries into the day.
- R5: After its last day, the day field returns to 01 and carries into the month. Months 01, 03, 05, 07, 08, 10 and 12 end at 31; months 04, 06, 09 and 11 end at 30. The weekday advances on every tick that advances the day, and it wraps from 6 to 0.
- R6: February ends at 29 when the year value is divisible by 4 (00, 04, ..., 96), and at 28 otherwise.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R8: While the stop bit is set, ticks are ignored. After the bit is cleared, counting resumes from whatever was loaded.
- R9: A tick in the same cycle as a write to any address from 0x2 to 0x8 is discarded. The written value is stored unchanged.
- R10: The invalid-time flag (seconds bit 7) is set by `rst_n` and by software reset. Writing the seconds register with bit 7 = 0 clears it. Writing bit 7 = 1 leaves the flag unchanged. Counting never changes the flag.
- R11: A control write with bits 6, 4 and 3 all set is a software reset. It returns every time field and the control register to the R1 values, sets the flag, and discards the other bits of that write. A later control write of 0x00 lets the clock run.
- R12: Control bits 2 and 7 are only stored. Hours always count in 24-hour form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |

## Verification
The bench sweeps every month of every year from 00 to 99, starting from the last second of the month's final day. A wrong month-length table or a wrong leap rule shows up as a day that does not return to 01 or that returns one day early. A broken carry shows up as a month or year that does not step, or a year 99 that does not wrap. A full hour of consecutive ticks is compared second by second, which catches BCD digit carries that skip or repeat values. Directed cases cover a tick arriving during a register write, ticks that occur while stopped, the flag surviving a write of 1, and reset patterns mixed with other control bits. In each case a faulty design would let time creep, lose the loaded value, or leave stale control bits behind.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NFIELD = 7;
  localparam int FIELD_BASE = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
  localparam logic [DATA_W-1:0] CTRL_MASK = 8'hA6;
  localparam logic [DATA_W-1:0] SRST_PAT = 8'h58;
  localparam int STOP_BIT = 5;
  localparam int FLAG_BIT = 7;

  // field index: 0 sec, 1 min, 2 hour, 3 day, 4 weekday, 5 month, 6 year
  localparam int F_DAY = 3;

  function automatic logic [DATA_W-1:0] field_mask(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h07;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] field_first(input int i);
    return (i == 3 || i == 5) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [DATA_W-1:0] field_last(input int i);
    case (i)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      4:       return 8'h06;
      5:       return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [DATA_W-1:0] month,
  input  logic [DATA_W-1:0] year,
  output logic [DATA_W-1:0] last_day
);
  logic [DATA_W-1:0] year_bin;
  logic              leap;

  always_comb begin
    year_bin = ({4'h0, year[7:4]} * 8'd10) + {4'h0, year[3:0]};
    leap     = (year_bin % 8'd4) == 8'd0;
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIRST   = '0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              step,
  input  logic [DATA_W-1:0] last,
  output logic [DATA_W-1:0] value,
  output logic              at_last
);
  assign at_last = value >= last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= RST_VAL;
    else if (soft_rst) value <= RST_VAL;
    else if (load)     value <= ld_val;
    else if (step)     value <= at_last ? FIRST : bcd_inc(value);
  end

  // R4: a stepped field at its last value restarts at its first value
  a_r4_wrap_first: assert property (@(posedge clk) disable iff (!rst_n)
    step && at_last && !load && !soft_rst |=> value == FIRST);
  // R8: no step, no load, no reset -> field holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !load && !soft_rst |=> $stable(value));
  // R9: a load stores the written value even when a step coincides
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load && !soft_rst |=> value == $past(ld_val));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] ADDR_FIRST = ADDR_W'(FIELD_BASE);
  localparam logic [ADDR_W-1:0] ADDR_LAST  = ADDR_W'(FIELD_BASE + NFIELD - 1);

  logic [DATA_W-1:0] ctrl_q;
  logic              flag_q;
  logic              soft_rst, time_wr, sec_wr, tick_en;
  logic [DATA_W-1:0] val_v  [NFIELD];
  logic [DATA_W-1:0] last_v [NFIELD];
  logic [NFIELD-1:0] at_last_v;
  logic [NFIELD-1:0] step_v;
  logic [DATA_W-1:0] day_last;
  logic              c_min, c_hr, c_day, c_mon, c_yr;

  assign soft_rst = wr_en && (addr == ADDR_CTRL) && ((wdata & SRST_PAT) == SRST_PAT);
  assign time_wr  = wr_en && (addr >= ADDR_FIRST) && (addr <= ADDR_LAST);
  assign sec_wr   = wr_en && (addr == ADDR_FIRST);
  assign tick_en  = tick_1hz && !ctrl_q[STOP_BIT] && !time_wr;

  // carry chain: weekday steps with the day
  assign c_min  = tick_en & at_last_v[0];
  assign c_hr   = c_min   & at_last_v[1];
  assign c_day  = c_hr    & at_last_v[2];
  assign c_mon  = c_day   & at_last_v[3];
  assign c_yr   = c_mon   & at_last_v[5];
  assign step_v = {c_yr, c_mon, c_day, c_day, c_hr, c_min, tick_en};

  rtc_month_len u_mlen (
    .month    (val_v[5]),
    .year     (val_v[6]),
    .last_day (day_last)
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    if (i == F_DAY) begin : g_dyn
      assign last_v[i] = day_last;
    end else begin : g_fix
      assign last_v[i] = field_last(i);
    end
    rtc_bcd_field #(
      .FIRST   (field_first(i)),
      .RST_VAL (field_first(i))
    ) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .load     (wr_en && (addr == ADDR_W'(FIELD_BASE + i))),
      .ld_val   (wdata & field_mask(i)),
      .step     (step_v[i]),
      .last     (last_v[i]),
      .value    (val_v[i]),
      .at_last  (at_last_v[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b1;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      flag_q <= 1'b1;
    end else begin
      if (wr_en && addr == ADDR_CTRL) ctrl_q <= wdata & CTRL_MASK;
      if (sec_wr && !wdata[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) rdata = ctrl_q;
    else if (addr == ADDR_FIRST) rdata = {flag_q, val_v[0][6:0]};
    else begin
      for (int i = 1; i < NFIELD; i++)
        if (addr == ADDR_W'(FIELD_BASE + i)) rdata = val_v[i];
    end
  end

  // R10: the flag only falls after a seconds write carrying bit 7 = 0
  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(sec_wr && !wdata[FLAG_BIT]));
  // R11: software reset leaves control cleared and the flag set
  a_r11_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> flag_q && ctrl_q == '0 && val_v[0] == '0);
  // R8: stopped and not written -> seconds do not move
  a_r8_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[STOP_BIT] && !wr_en |=> $stable(val_v[0]));
  // R5: weekday stepping from its last value returns to 0
  a_r5_wd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step_v[4] && at_last_v[4] && !wr_en |=> val_v[4] == '0);
  // R7: year stepping from 99 returns to 00
  a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    c_yr && at_last_v[6] && !wr_en |=> val_v[6] == '0);
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  rtc_calendar_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #5 clk = ~clk;

  function automatic int bcd(input int n);
    return (n / 10) * 16 + (n % 10);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic expect_reg(input string req, input int a, input int exp);
    int v;
    @(negedge clk);
    addr = 4'(a);
    #1 v = int'(rdata);
    chk(req, v, exp);
  endtask

  task automatic load_time(input int s, input int mi, input int h, input int d,
                           input int wd, input int mo, input int y);
    wr(2, bcd(s)); wr(3, bcd(mi)); wr(4, bcd(h)); wr(5, bcd(d));
    wr(6, wd); wr(7, bcd(mo)); wr(8, bcd(y));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_reg("R1 ctrl", 0, 8'h00);
    expect_reg("R1 sec", 2, 8'h80);
    expect_reg("R1 min", 3, 8'h00);
    expect_reg("R1 hour", 4, 8'h00);
    expect_reg("R1 day", 5, 8'h01);
    expect_reg("R1 wday", 6, 8'h00);
    expect_reg("R1 month", 7, 8'h01);
    expect_reg("R1 year", 8, 8'h00);

    // R10 flag behaviour
    wr(2, 8'h85); expect_reg("R10 write 1 keeps flag", 2, 8'h85);
    wr(2, 8'h05); expect_reg("R10 write 0 clears", 2, 8'h05);
    wr(2, 8'h85); expect_reg("R10 write 1 no set", 2, 8'h05);
    tk();         expect_reg("R10 tick keeps clear", 2, 8'h06);

    // R2 masks and unmapped addresses
    wr(3, 8'hFF); expect_reg("R2 min mask", 3, 8'h7F);
    wr(4, 8'hFF); expect_reg("R2 hour mask", 4, 8'h3F);
    wr(5, 8'hFF); expect_reg("R2 day mask", 5, 8'h3F);
    wr(6, 8'hFF); expect_reg("R2 wday mask", 6, 8'h07);
    wr(7, 8'hFF); expect_reg("R2 month mask", 7, 8'h1F);
    wr(8, 8'hFF); expect_reg("R2 year mask", 8, 8'hFF);
    wr(0, 8'hA6); expect_reg("R2 ctrl bits", 0, 8'hA6);
    wr(0, 8'h1F); expect_reg("R2 ctrl partial pattern", 0, 8'h06);
    wr(1, 8'hFF); expect_reg("R2 addr1 reads 0", 1, 8'h00);
    wr(9, 8'h12); expect_reg("R2 addr9 reads 0", 9, 8'h00);
    expect_reg("R2 unmapped write no effect", 3, 8'h7F);
    expect_reg("R2 addrF reads 0", 15, 8'h00);

    // R12 12-hour bit set (ctrl = 0x06): counting stays 24-hour
    load_time(59, 59, 12, 10, 1, 3, 5);
    tk();
    expect_reg("R12 hour 12->13", 4, 8'h13);
    expect_reg("R4 min carry", 3, 8'h00);
    load_time(59, 59, 23, 10, 1, 3, 5);
    tk();
    expect_reg("R12 hour 23->00", 4, 8'h00);
    expect_reg("R4 day carry", 5, 8'h11);

    // R8 stop
    wr(0, 8'h20);
    tk(); expect_reg("R8 stopped", 2, 8'h00);
    wr(2, 8'h30); tk(); expect_reg("R8 load while stopped", 2, 8'h30);
    wr(0, 8'h00); tk(); expect_reg("R8 resume", 2, 8'h31);

    // R9 tick during a time write
    @(negedge clk);
    addr = 4'h3; wdata = 8'h10; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    expect_reg("R9 tick dropped", 2, 8'h31);
    expect_reg("R9 write kept", 3, 8'h10);

    // R3 tick and idle
    tk(); expect_reg("R3 tick", 2, 8'h32);
    repeat (5) @(negedge clk);
    expect_reg("R3 idle", 2, 8'h32);

    // R11 software reset
    wr(0, 8'h58);
    expect_reg("R11 ctrl", 0, 8'h00);
    expect_reg("R11 sec flag", 2, 8'h80);
    expect_reg("R11 min", 3, 8'h00);
    expect_reg("R11 day", 5, 8'h01);
    expect_reg("R11 month", 7, 8'h01);
    expect_reg("R11 year", 8, 8'h00);
    wr(0, 8'h00); tk(); expect_reg("R11 runs after 0x00", 2, 8'h81);
    wr(3, 8'h05); wr(0, 8'hFE);
    expect_reg("R11 other bits discarded", 0, 8'h00);
    expect_reg("R11 min cleared", 3, 8'h00);
    wr(0, 8'h00);

    // R3/R4 one-hour sweep
    load_time(0, 0, 23, 15, 2, 6, 23);
    for (int n = 1; n <= 3600; n++) begin
      tk();
      expect_reg("R3 sweep sec", 2, bcd(n % 60));
      expect_reg("R4 sweep min", 3, bcd((n / 60) % 60));
    end
    expect_reg("R4 hour wrap", 4, 8'h00);
    expect_reg("R4 day step", 5, 8'h16);
    expect_reg("R5 wday step", 6, 8'h03);

    // R5/R6/R7 calendar sweep
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int wd;
        wd = (y + m) % 7;
        load_time(59, 59, 23, mdays(m, y), wd, m, y);
        tk();
        expect_reg(m == 2 ? "R6 feb end" : "R5 month end", 5, 8'h01);
        expect_reg("R5 wday", 6, (wd + 1) % 7);
        expect_reg("R7 month", 7, bcd(m == 12 ? 1 : m + 1));
        expect_reg("R7 year", 8, bcd(m == 12 ? (y + 1) % 100 : y));
      end
      load_time(59, 59, 23, 28, 0, 2, y);
      tk();
      expect_reg("R6 feb 28", 5, (y % 4 == 0) ? 8'h29 : 8'h01);
    end

    done = 1'b1;
    finish_run();
  end
endmodule